// File: doc/BRIEF.md
# SHA-1 Message Schedule Finisher

This block computes the next four SHA-1 message schedule words from two 128-bit operands, each packed with four 32-bit words. The first operand holds partial words that an earlier scheduling step has already XOR-combined. The second operand holds the three most recent schedule words. Each new word is the XOR of a partial word and an older schedule word, rotated left by one bit.

The words are packed with the highest word first, so the lane index runs opposite to the schedule index. The last word of the group cannot be computed on its own. It takes its second XOR input from the first word of the same group, so the datapath contains a serial chain inside one operation.

Operands are taken through a valid/ready handshake. The result is held in a 128-bit output register until the consumer takes it. The block produces no status flags.

Top module: `sha1_sched_finish`

## Requirements
- R1: The top result word, out_data[127:96], equals rotl1(in_a[127:96] XOR in_b[95:64]).
- R2: out_data[95:64] equals rotl1(in_a[95:64] XOR in_b[63:32]), and out_data[63:32] equals rotl1(in_a[63:32] XOR in_b[31:0]).
- R3: The bottom result word, out_data[31:0], equals rotl1(in_a[31:0] XOR W), where W is the top result word of the same operation.
- R4: in_b[127:96] has no effect on any bit of the result.
- R5: rotl1 is a 32-bit circular left shift by one position, so bit 31 of the XOR value lands in bit 0.
- R6: An operand pair is accepted at a rising edge where in_valid and in_ready are both high. From that edge on, out_valid is high and out_data holds the result.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R8: in_ready is low exactly when out_valid is high and out_ready is low.
- R9: A synchronous active-high reset clears out_valid and out_data to zero.
- R10: A result is consumed at an edge where out_valid and out_ready are both high. If no new pair is accepted at that same edge, out_valid is low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The block can take an operand pair |
| in_a | input | 128 | Partial words, highest lane first |
| in_b | input | 128 | Previous schedule words in the lower three lanes |
| out_valid | output | 1 | out_data holds an untaken result |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | 128 | Four new schedule words, first word in bits 127:96 |

## Verification
The bench targets lane order and the chained last word. A design that reverses lanes, or feeds the last word from the old schedule operand instead of the fresh top word, yields wrong values in single lanes, and the per-lane comparison against the behavioural model catches this. Rotation direction is pinned by operands whose XOR sets only bit 31 or only bit 0: a right rotate or a plain shift drops or misplaces that bit. Back-pressure sequences with long stalls, together with handshakes that accept and consume at the same edge, expose a result overwritten during a stall, a lost result, and out_valid left high after the consumer has taken its word.

// File: rtl/sha1_fin_pkg.sv
package sha1_fin_pkg;
    parameter int WORD_W  = 32;
    parameter int LANES   = 4;
    parameter int ROT_AMT = 1;
    localparam int QUAD_W = WORD_W * LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [LANES-1:0] lanes_t;

    typedef struct packed {
        lanes_t part;
        lanes_t prev;
    } operand_t;

    function automatic word_t rotl_w(input word_t x);
        return (x << ROT_AMT) | (x >> (WORD_W - ROT_AMT));
    endfunction
endpackage

// File: rtl/sha1_fin_lane.sv
module sha1_fin_lane
    import sha1_fin_pkg::*;
(
    input  word_t part_word,
    input  word_t mix_word,
    output word_t new_word
);
    word_t folded;
    always_comb begin
        folded   = part_word ^ mix_word;
        new_word = rotl_w(folded);
    end
endmodule

// File: rtl/sha1_fin_core.sv
module sha1_fin_core
    import sha1_fin_pkg::*;
(
    input  operand_t ops,
    output lanes_t   result
);
    lanes_t mix;

    // lanes above 0 pair with the next lower lane of the history operand
    for (genvar k = 1; k < LANES; k++) begin : g_indep
        assign mix[k] = ops.prev[k-1];
        sha1_fin_lane u_lane (
            .part_word (ops.part[k]),
            .mix_word  (mix[k]),
            .new_word  (result[k])
        );
    end

    // lane 0 chains the freshly computed top lane
    assign mix[0] = result[LANES-1];
    sha1_fin_lane u_lane_chain (
        .part_word (ops.part[0]),
        .mix_word  (mix[0]),
        .new_word  (result[0])
    );

    // the top history lane carries no information for this step
    logic unused_prev_top;
    assign unused_prev_top = ^ops.prev[LANES-1];
endmodule

// File: rtl/sha1_fin_outreg.sv
module sha1_fin_outreg
    import sha1_fin_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  lanes_t load_data,
    input  logic   take,
    output logic   held_valid,
    output lanes_t held_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_data  <= '0;
        end else if (load) begin
            held_valid <= 1'b1;
            held_data  <= load_data;
        end else if (take) begin
            held_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sha1_sched_finish.sv
module sha1_sched_finish
    import sha1_fin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [QUAD_W-1:0] in_a,
    input  logic [QUAD_W-1:0] in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [QUAD_W-1:0] out_data
);
    operand_t ops;
    lanes_t   fresh;
    lanes_t   held;
    logic     accept;

    assign ops.part = lanes_t'(in_a);
    assign ops.prev = lanes_t'(in_b);

    sha1_fin_core u_core (
        .ops    (ops),
        .result (fresh)
    );

    assign in_ready = ~out_valid | out_ready;
    assign accept   = in_valid & in_ready;

    sha1_fin_outreg u_out (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_data  (fresh),
        .take       (out_ready),
        .held_valid (out_valid),
        .held_data  (held)
    );

    assign out_data = QUAD_W'(held);
endmodule

// File: rtl/sha1_fin_chk.sv
module sha1_fin_chk
    import sha1_fin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [QUAD_W-1:0] in_a,
    input logic              out_valid,
    input logic              out_ready,
    input logic [QUAD_W-1:0] out_data
);
    assert_chain_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=>
        out_data[WORD_W-1:0] == rotl_w($past(in_a[WORD_W-1:0]) ^ out_data[QUAD_W-1:QUAD_W-WORD_W]));

    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    assert_drain_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind sha1_sched_finish sha1_fin_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_sha1_sched_finish.sv
module sim_sha1_sched_finish;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bit           exp_valid = 1'b0;
    logic [127:0] exp_data = '0;
    bit           stalled = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha1_sched_finish u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    function automatic int unsigned rol1(input int unsigned x);
        return (x << 1) | (x >> 31);
    endfunction

    // schedule-index model: w[13..15] from history, w[16..19] new
    function automatic logic [127:0] ref_fin(input logic [127:0] a, input logic [127:0] b);
        int unsigned w[20];
        int unsigned p[4];
        for (int i = 0; i < 4; i++) p[i] = a[127 - 32*i -: 32];
        w[13] = b[95:64];
        w[14] = b[63:32];
        w[15] = b[31:0];
        for (int i = 0; i < 4; i++) begin
            int unsigned other;
            other = (i == 3) ? w[16] : w[13 + i];
            w[16 + i] = rol1(p[i] ^ other);
        end
        return {w[16], w[17], w[18], w[19]};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare at the next negedge
    task automatic step(input bit v, input logic [127:0] a, input logic [127:0] b,
                        input bit rdy, input bit r);
        bit acc;
        in_valid = v; in_a = a; in_b = b; out_ready = rdy; rst = r;
        #1;
        check("R8 in_ready", {127'b0, in_ready}, {127'b0, (!exp_valid || rdy)});
        acc = v && (!exp_valid || rdy);
        stalled = exp_valid && !rdy && !r;
        if (r) begin
            exp_valid = 1'b0; exp_data = '0;
        end else if (acc) begin
            exp_valid = 1'b1; exp_data = ref_fin(a, b);
        end else if (rdy) begin
            exp_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            check("R9 reset out_valid", {127'b0, out_valid}, 128'b0);
            check("R9 reset out_data", out_data, 128'b0);
        end else begin
            check(acc ? "R6 out_valid" : (stalled ? "R7 out_valid" : "R10 out_valid"),
                  {127'b0, out_valid}, {127'b0, exp_valid});
            if (exp_valid) begin
                check(stalled ? "R7 hold lane3 R1" : "R1 lane3", {96'b0, out_data[127:96]}, {96'b0, exp_data[127:96]});
                check("R2 lane2", {96'b0, out_data[95:64]}, {96'b0, exp_data[95:64]});
                check("R2 lane1", {96'b0, out_data[63:32]}, {96'b0, exp_data[63:32]});
                check("R3 lane0", {96'b0, out_data[31:0]}, {96'b0, exp_data[31:0]});
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] r_a;
        logic [127:0] r_b;
        logic [127:0] first;
        @(negedge clk);
        step(0, '0, '0, 0, 1);
        step(0, '0, '0, 0, 1);

        // R5: XOR sets only bit 31 of the top lane -> top word 1,
        // chained bottom lane with zero partial -> 2
        step(1, {32'h8000_0000, 96'b0}, '0, 1, 0);
        check("R5 rotate msb to lsb", out_data, {32'h0000_0001, 64'b0, 32'h0000_0002});
        // R5: bit 0 only in lane 1 via history -> bit 1
        step(1, '0, {96'b0, 32'h0000_0001}, 1, 0);
        check("R5 rotate lsb", out_data, {64'b0, 32'h0000_0002, 32'b0});
        // R3: chain value differs from history lane
        step(1, {32'h1234_5678, 64'b0, 32'hFFFF_FFFF},
                {32'h0, 32'h0F0F_0F0F, 64'b0}, 1, 0);

        // R4: only the top history lane differs
        r_a = {32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hCAFE_BABE, 32'h1357_9BDF};
        r_b = {32'h0000_0000, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0F1E_2D3C};
        step(1, r_a, r_b, 1, 0);
        first = out_data;
        step(1, r_a, {32'hFFFF_FFFF, r_b[95:0]}, 1, 0);
        check("R4 top history lane ignored", out_data, first);

        // R7/R8: long stall then drain
        step(1, r_a, r_b, 0, 0);
        for (int i = 0; i < 5; i++) step(1, ~r_a, ~r_b, 0, 0);
        step(0, '0, '0, 1, 0);
        step(0, '0, '0, 1, 0);

        // mixed random traffic with a reset in the middle
        for (int n = 0; n < 3000; n++) begin
            bit v;
            bit rdy;
            v = ($urandom % 10) < 6;
            rdy = ($urandom % 10) < 7;
            r_a = {$urandom, $urandom, $urandom, $urandom};
            r_b = {$urandom, $urandom, $urandom, $urandom};
            step(v, r_a, r_b, rdy, n == 1500);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule